// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Aggregator

This block gathers a vector of external interrupt request lines into one interrupt line for a processor. Every source has its own trigger type, chosen by a pair of bits (mode, polarity): rising edge, falling edge, active-high level or active-low level. Each input first passes through a two-flop synchroniser. A detected event sets a sticky pending bit. Software clears a pending bit by writing a one to it. Software can also raise any pending bit through a force register.

A per-source enable register masks each pending bit before the bits are ORed into one request. Masking never clears a pending bit. The request drives the interrupt line in one of two styles: a steady level, or a single-cycle pulse each time the request becomes active. The active polarity of the line is programmable. All settings are held in 32-bit registers behind a simple word-wide write strobe and a combinational read port addressed by byte offset.

Top module: `irq_trig_ctrl`

## Requirements
- R1: After reset, enable, output mode and output polarity read 0, status reads 0, source mode and source polarity read all ones (every source on rising edge), and `irq_o` is high (inactive, active-low).
- R2: Writing the status register (offset 0x04) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: Source encoding {mode=1, polarity=1} sets the status bit on a rising edge of the synchronised input and ignores falling edges.
- R4: Source encoding {mode=1, polarity=0} sets the status bit on a falling edge and ignores rising edges.
- R5: Source encoding {mode=0, polarity=1} sets the status bit while the input is high. A clear has no lasting effect while the input stays high.
- R6: Source encoding {mode=0, polarity=0} sets the status bit while the input is low. A clear has no lasting effect while the input stays low.
- R7: When an event on a source and a write-1 clear of that bit fall in the same cycle, the bit stays set.
- R8: An enable bit of 0 (offset 0x00) keeps the source out of the interrupt line but preserves its status bit. An enable bit of 1 lets the source through.
- R9: With output mode 0 (offset 0x10, bit 0) the line is active whenever any enabled status bit is set. Output polarity (offset 0x14, bit 0) set to 1 makes the line active-high, and 0 makes it active-low.
- R10: With output mode 1 the line is active for exactly one cycle each time the OR of enabled status bits goes from 0 to 1.
- R11: Writing 1 to a bit of the force register (offset 0x18) sets that status bit. The force register reads as 0.
- R12: Reads from offsets other than 0x00 to 0x18 return 0. Writes to such offsets change no register.
- R13: Enable (0x00), source mode (0x08), source polarity (0x0C), output mode (0x10) and output polarity (0x14) read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Write strobe for one register word |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Aggregated interrupt line |

## Verification
The trigger logic is driven by random settings of all 32 encodings together with random before and after input vectors. The expected status is then a per-bit function of encoding and both input values, which separates edge from level detection and rising from falling cases. Directed sequences place a clear in the very cycle an edge is detected, to tell whether the edge or the clear wins. Further directed sequences toggle the enable while a bit is pending, to show that masking does not clear it. A single forced event in pulse mode separates a one-cycle pulse from a held level, and both output polarities are checked.

// File: rtl/irq_trig_pkg.sv
// Package: register offsets shared by the interrupt aggregator modules.
// Assumes byte addressing with one 32-bit word per register.
package irq_trig_pkg;
    localparam int OFS_ENABLE = 'h00;
    localparam int OFS_STATUS = 'h04;
    localparam int OFS_SMODE  = 'h08;
    localparam int OFS_SPOL   = 'h0C;
    localparam int OFS_OMODE  = 'h10;
    localparam int OFS_OPOL   = 'h14;
    localparam int OFS_FORCE  = 'h18;
endpackage

// File: rtl/irq_src_detect.sv
// Module: synchronises each source line and flags a trigger event per source.
// Assumes {mode,pol}: 11 rising, 10 falling, 01 high level, 00 low level.
module irq_src_detect #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] smode_i,
    input  logic [NSRC-1:0] spol_i,
    output logic [NSRC-1:0] evt_o
);
    logic [NSRC-1:0] meta_q, sync_q, prev_q;
    logic [NSRC-1:0] rise, fall, lvl;

    // Two-flop synchroniser plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Per-source event selection from the trigger encoding.
    always_comb begin
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
        lvl   = ~(sync_q ^ spol_i);
        evt_o = (smode_i & ((spol_i & rise) | (~spol_i & fall))) | (~smode_i & lvl);
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & smode_i & ~(sync_q ^ prev_q)) == '0)); // R3
endmodule

// File: rtl/irq_regs.sv
// Module: register file and sticky status for the interrupt aggregator.
// Assumes a one-cycle write strobe and a combinational read of bus_addr.
module irq_regs #(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   evt_i,
    output logic [NSRC-1:0]   smode_o,
    output logic [NSRC-1:0]   spol_o,
    output logic [NSRC-1:0]   pend_o,
    output logic              omode_o,
    output logic              opol_o
);
    import irq_trig_pkg::*;

    logic [NSRC-1:0] en_q, status_q, smode_q, spol_q, omode_q, opol_q;
    logic [NSRC-1:0] clr_mask, frc_mask;
    logic            wr_en, wr_smode, wr_spol, wr_omode, wr_opol;

    // Address decode of the write strobe.
    always_comb begin
        wr_en    = bus_wr && (bus_addr == ADDR_W'(OFS_ENABLE));
        wr_smode = bus_wr && (bus_addr == ADDR_W'(OFS_SMODE));
        wr_spol  = bus_wr && (bus_addr == ADDR_W'(OFS_SPOL));
        wr_omode = bus_wr && (bus_addr == ADDR_W'(OFS_OMODE));
        wr_opol  = bus_wr && (bus_addr == ADDR_W'(OFS_OPOL));
        clr_mask = (bus_wr && (bus_addr == ADDR_W'(OFS_STATUS))) ? bus_wdata : '0;
        frc_mask = (bus_wr && (bus_addr == ADDR_W'(OFS_FORCE)))  ? bus_wdata : '0;
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            smode_q <= '1;
            spol_q  <= '1;
            omode_q <= '0;
            opol_q  <= '0;
        end else begin
            if (wr_en)    en_q    <= bus_wdata;
            if (wr_smode) smode_q <= bus_wdata;
            if (wr_spol)  spol_q  <= bus_wdata;
            if (wr_omode) omode_q <= bus_wdata;
            if (wr_opol)  opol_q  <= bus_wdata;
        end
    end

    // Sticky status: events and forces set, write-1 clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | evt_i | frc_mask;
    end

    // Combinational read mux; force and unmapped offsets read zero.
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_ENABLE): bus_rdata = en_q;
            ADDR_W'(OFS_STATUS): bus_rdata = status_q;
            ADDR_W'(OFS_SMODE):  bus_rdata = smode_q;
            ADDR_W'(OFS_SPOL):   bus_rdata = spol_q;
            ADDR_W'(OFS_OMODE):  bus_rdata = omode_q;
            ADDR_W'(OFS_OPOL):   bus_rdata = opol_q;
            default:             bus_rdata = '0;
        endcase
    end

    assign smode_o = smode_q;
    assign spol_o  = spol_q;
    assign pend_o  = status_q & en_q;
    assign omode_o = omode_q[0];
    assign opol_o  = opol_q[0];

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STATUS)) |=> ((status_q & $past(bus_wdata) & ~$past(evt_i)) == '0)); // R2
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R7
    AST_STATUS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_STATUS)) |=> ((status_q & $past(status_q)) == $past(status_q))); // R8
    AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_FORCE)) |-> (bus_rdata == '0)); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) > OFS_FORCE) |-> (bus_rdata == '0)); // R12
endmodule

// File: rtl/irq_out_stage.sv
// Module: reduces enabled pending bits to one line, in level or pulse style.
// Assumes pend_i comes from registers; the line is registered once.
module irq_out_stage #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend_i,
    input  logic            omode_i,
    input  logic            opol_i,
    output logic            irq_o
);
    logic any_req, any_q, act_q;

    assign any_req = |pend_i;

    // Register the request and shape it as level or one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= 1'b0;
            act_q <= 1'b0;
        end else begin
            any_q <= any_req;
            act_q <= omode_i ? (any_req & ~any_q) : any_req;
        end
    end

    // Apply the programmed polarity: 1 active-high, 0 active-low.
    assign irq_o = ~(act_q ^ opol_i);

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> !act_q); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (omode_i && act_q) |=> !act_q); // R10
endmodule

// File: rtl/irq_trig_ctrl.sv
// Module: top of the programmable-trigger interrupt aggregator.
// Assumes src_i is asynchronous; the bus is synchronous to clk.
module irq_trig_ctrl #(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq_o
);
    logic [NSRC-1:0] evt, smode, spol, pend;
    logic            omode, opol;

    irq_src_detect #(.NSRC(NSRC)) u_detect (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .smode_i(smode), .spol_i(spol), .evt_o(evt)
    );

    irq_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt),
        .smode_o(smode), .spol_o(spol), .pend_o(pend),
        .omode_o(omode), .opol_o(opol)
    );

    irq_out_stage #(.NSRC(NSRC)) u_out (
        .clk(clk), .rst_n(rst_n), .pend_i(pend),
        .omode_i(omode), .opol_i(opol), .irq_o(irq_o)
    );
endmodule

// File: tb/irq_trig_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_trig_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_trig_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected status after a clear with input a held, then input b held.
    function automatic logic [31:0] exp_status(input logic [31:0] m, input logic [31:0] p,
                                               input logic [31:0] a, input logic [31:0] b);
        logic [31:0] rise_b = ~a & b;
        logic [31:0] fall_b = a & ~b;
        logic [31:0] lvl_b  = (p & (a | b)) | (~p & (~a | ~b));
        return (m & p & rise_b) | (m & ~p & fall_b) | (~m & lvl_b);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, m, p, a, b, en;
        void'($urandom(32'h1234_5678));
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(8'h00, d); chk("R1 enable", d, 32'h0);
        rd(8'h04, d); chk("R1 status", d, 32'h0);
        rd(8'h08, d); chk("R1 smode", d, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R1 spol", d, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R1 omode", d, 32'h0);
        rd(8'h14, d); chk("R1 opol", d, 32'h0);
        chk("R1 irq_o", {31'b0, irq_o}, 32'h1);

        // R13 readback
        wr(8'h00, 32'hA5A5_0F0F); rd(8'h00, d); chk("R13 enable", d, 32'hA5A5_0F0F);
        wr(8'h08, 32'h1234_5678); rd(8'h08, d); chk("R13 smode", d, 32'h1234_5678);
        wr(8'h0C, 32'h8765_4321); rd(8'h0C, d); chk("R13 spol", d, 32'h8765_4321);
        wr(8'h10, 32'h0000_0001); rd(8'h10, d); chk("R13 omode", d, 32'h1);
        wr(8'h14, 32'h0000_0001); rd(8'h14, d); chk("R13 opol", d, 32'h1);
        wr(8'h00, 0); wr(8'h08, '1); wr(8'h0C, '1); wr(8'h10, 0); wr(8'h14, 0);
        idle(3); wr(8'h04, '1);

        // R11 force and readback zero; R2 clear semantics
        wr(8'h18, 32'h0000_000F);
        rd(8'h04, d); chk("R11 force sets", d, 32'hF);
        rd(8'h18, d); chk("R11 force reads 0", d, 32'h0);
        wr(8'h04, 32'h5); rd(8'h04, d); chk("R2 clear ones", d, 32'hA);
        wr(8'h04, 32'h0); rd(8'h04, d); chk("R2 zero no effect", d, 32'hA);
        wr(8'h04, '1);

        // R12 unmapped offsets
        wr(8'h1C, '1); wr(8'h40, '1);
        rd(8'h1C, d); chk("R12 read 0x1C", d, 32'h0);
        rd(8'h80, d); chk("R12 read 0x80", d, 32'h0);
        rd(8'h00, d); chk("R12 enable untouched", d, 32'h0);
        rd(8'h04, d); chk("R12 status untouched", d, 32'h0);
        rd(8'h0C, d); chk("R12 spol untouched", d, 32'hFFFF_FFFF);
        chk("R12 irq untouched", {31'b0, irq_o}, 32'h1);

        // R3 rising edge on bit 3
        src_i[3] = 1'b1; idle(5);
        rd(8'h04, d); chk("R3 rise sets", d, 32'h8);
        wr(8'h04, '1); src_i[3] = 1'b0; idle(5);
        rd(8'h04, d); chk("R3 fall ignored", d, 32'h0);

        // R4 falling edge on bit 4
        wr(8'h0C, ~32'h10); idle(3); wr(8'h04, '1);
        src_i[4] = 1'b1; idle(5);
        rd(8'h04, d); chk("R4 rise ignored", d, 32'h0);
        src_i[4] = 1'b0; idle(5);
        rd(8'h04, d); chk("R4 fall sets", d, 32'h10);
        wr(8'h0C, '1); wr(8'h04, '1);

        // R5 high level on bit 5
        wr(8'h08, ~32'h20); idle(3); wr(8'h04, '1);
        src_i[5] = 1'b1; idle(5);
        rd(8'h04, d); chk("R5 level sets", d, 32'h20);
        wr(8'h04, '1); rd(8'h04, d); chk("R5 clear no lasting effect", d, 32'h20);
        src_i[5] = 1'b0; idle(5); wr(8'h04, '1);
        rd(8'h04, d); chk("R5 clears when low", d, 32'h0);

        // R6 low level on bit 6
        wr(8'h0C, ~32'h40); wr(8'h08, ~32'h40); idle(3);
        rd(8'h04, d); chk("R6 low level sets", d, 32'h40);
        wr(8'h04, '1); rd(8'h04, d); chk("R6 clear no lasting effect", d, 32'h40);
        src_i[6] = 1'b1; idle(5); wr(8'h04, '1);
        rd(8'h04, d); chk("R6 clears when high", d, 32'h0);
        src_i[6] = 1'b0; wr(8'h08, '1); wr(8'h0C, '1); idle(3); wr(8'h04, '1);

        // R7 edge detected in the same cycle as a clear of that bit
        wr(8'h18, 32'h4);
        @(negedge clk) src_i[2] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(8'h04, 32'h4);
        rd(8'h04, d); chk("R7 edge beats clear", d, 32'h4);
        src_i[2] = 1'b0; idle(4); wr(8'h04, '1);

        // R8 masking keeps status; R9 level output and polarity
        wr(8'h18, 32'h1); idle(3);
        chk("R8 masked irq inactive", {31'b0, irq_o}, 32'h1);
        wr(8'h00, 32'h1); idle(2);
        chk("R8/R9 active-low irq", {31'b0, irq_o}, 32'h0);
        wr(8'h00, 32'h0); idle(2);
        chk("R8 masked again", {31'b0, irq_o}, 32'h1);
        rd(8'h04, d); chk("R8 status kept", d, 32'h1);
        wr(8'h00, 32'h1); wr(8'h14, 32'h1); idle(2);
        chk("R9 active-high irq", {31'b0, irq_o}, 32'h1);
        wr(8'h04, '1); idle(2);
        chk("R9 idle after clear", {31'b0, irq_o}, 32'h0);

        // R10 pulse mode
        wr(8'h10, 32'h1); wr(8'h00, 32'h2); idle(2);
        wr(8'h18, 32'h2);
        @(posedge clk); @(negedge clk);
        chk("R10 pulse high", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R10 pulse one cycle", {31'b0, irq_o}, 32'h0);
        idle(3);
        chk("R10 stays low while pending", {31'b0, irq_o}, 32'h0);
        wr(8'h04, '1); wr(8'h10, 0); wr(8'h00, 0);

        // Random trigger encodings and input patterns (R3 R4 R5 R6 R9)
        for (int it = 0; it < 40; it++) begin
            m = $urandom; p = $urandom; a = $urandom; b = $urandom; en = $urandom;
            src_i = a;
            wr(8'h00, 0); wr(8'h08, m); wr(8'h0C, p); idle(4);
            wr(8'h04, '1);
            src_i = b; idle(5);
            rd(8'h04, d); chk("R3-6 random status R3 R4 R5 R6", d, exp_status(m, p, a, b));
            wr(8'h00, en); idle(2);
            chk("R9 random level", {31'b0, irq_o}, {31'b0, |(exp_status(m, p, a, b) & en)});
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule